// File: doc/BRIEF.md
# Serial Wire Debug Host Transfer Engine

This block is the host end of a two-wire debug link. From a system clock it makes a divided wire clock and runs one register transfer at a time on a shared data pin, which is split into a drive value, a drive enable and a sampled input. A caller gives a port select (debug port or access port), a read/write flag, a two-bit register index and a write word, then pulses a start strobe. The engine sends an eight-bit request packet and hands the pin to the target for one idle turnaround slot. It then collects a three-bit acknowledge and, only when that acknowledge means success, moves a 32-bit word with its parity bit in the requested direction.

When the transfer ends the engine pulses `done` for one cycle. In that same cycle it updates the reported acknowledge, the read word and the parity-error flag. Any acknowledge other than success ends the transfer straight after the acknowledge. The retry policy for a busy target, link set-up sequences and access-port bank selection belong to the caller.

Top module: `swd_xfer_engine`

## Requirements
- R1: After reset `swclk` is 0, `swdioOe` is 1 with `swdioOut` 0, and `busy`, `done`, `ack`, `rdata` and `parityErr` are all zero.
- R2: The request goes out with `swdioOe` high as eight wire bits, first bit first: 1, port select (1 = access port), read flag (1 = read), `cmdAddr[0]`, `cmdAddr[1]`, the even parity of those four bits, 0, 1.
- R3: The host releases the pin (`swdioOe` 0) for one slot after the request and for the three acknowledge slots. The acknowledge is taken first bit into `ack[0]`, and the value 3'b001 means success.
- R4: On a write with a successful acknowledge, one released slot follows the acknowledge. The host then drives 32 data bits, least significant first, and then their even-parity bit.
- R5: On a read with a successful acknowledge, 32 bits (least significant first) and a parity bit are sampled. One released slot follows them, and `rdata` takes the word at completion.
- R6: `parityErr` is 1 after a successful read whose received parity bit differs from the even parity of the received word. It is 0 after every other transfer.
- R7: Any acknowledge other than 3'b001 (including 3'b010, 3'b100 and invalid codes) skips the data phase. The transfer then makes exactly 13 wire-clock pulses, leaves `rdata` unchanged and clears `parityErr`.
- R8: Each wire-clock period lasts 2*(`divHalf`+1) system cycles. The pin outputs change only where `swclk` falls or while it is low, `swclk` rests low when idle, and `done` is never high while `swclk` is high.
- R9: `busy` rises only after a start pulse. A start pulse while `busy` is high is ignored. `done` is a single-cycle pulse, one per accepted start.
- R10: A transfer with a successful acknowledge makes exactly 46 wire-clock pulses in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divHalf | input | DIV_W | Half wire-clock period in system cycles, minus one |
| cmdStart | input | 1 | Start pulse, taken only when idle |
| cmdApSel | input | 1 | 1 selects the access port, 0 the debug port |
| cmdRead | input | 1 | 1 for read, 0 for write |
| cmdAddr | input | 2 | Register index (byte offset divided by four) |
| cmdWdata | input | DATA_W | Word for a write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| ack | output | 3 | Acknowledge of the last transfer |
| rdata | output | DATA_W | Word of the last successful read |
| parityErr | output | 1 | Parity mismatch on the last read |
| swclk | output | 1 | Wire clock |
| swdioOut | output | 1 | Data pin drive value |
| swdioOe | output | 1 | Data pin drive enable |
| swdioIn | input | 1 | Data pin sampled value |

## Verification
A slot counter or phase that has drifted shows at once on the pin. The request bits seen at the first eight rising wire-clock edges differ, or the drive enable is high in a slot where the target owns the line. A bad acknowledge branch changes the pulse count within a few dozen wire-clock periods: 13 instead of 46, or the reverse. A wrong shift or capture appears as a mismatch in `ack`, `rdata` or `parityErr` in the single `done` cycle, and a stale or extra completion shows as a missing or surplus `done` pulse.

// File: rtl/swd_xfer_pkg.sv
`timescale 1ns/1ps
package swd_xfer_pkg;

  // Transfer slot groups, in wire order
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_TRN1,
    PH_ACK,
    PH_TRN2,
    PH_WDATA,
    PH_RDATA,
    PH_TRN3
  } xferPhase_e;

  // Source of the pin drive value
  typedef enum logic [1:0] {
    DRV_IDLE,
    DRV_REQ,
    DRV_WDATA,
    DRV_WPAR
  } drvSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    shiftReq;
    logic    shiftWr;
    logic    sampleAck;
    logic    sampleRd;
    logic    samplePar;
    logic    finish;
    logic    drvEn;
    drvSel_e drvSel;
  } strobe_t;

  localparam logic [2:0] ACK_OK = 3'b001;

endpackage

// File: rtl/swd_xfer_ctrl.sv
`timescale 1ns/1ps
module swd_xfer_ctrl
  import swd_xfer_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             cmdStart,
  input  logic             cmdRead,
  input  logic             ackOk,
  output strobe_t          stb,
  output logic             swclk,
  output logic             busy
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] REQ_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0] ACK_LAST  = CNT_W'(2);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W);

  xferPhase_e       phase;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             swclkQ;
  logic             isRead;
  logic             tick;
  logic             riseEv;
  logic             fallEv;

  assign busy   = (phase != PH_IDLE);
  assign swclk  = swclkQ;
  assign tick   = (divCnt == divHalf);
  assign riseEv = busy && !swclkQ && tick;
  assign fallEv = busy && swclkQ && tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitCnt <= '0;
      divCnt <= '0;
      swclkQ <= 1'b0;
      isRead <= 1'b0;
    end else if (!busy) begin
      divCnt <= '0;
      swclkQ <= 1'b0;
      if (cmdStart) begin
        phase  <= PH_REQ;
        bitCnt <= '0;
        isRead <= cmdRead;
      end
    end else begin
      if (tick) begin
        divCnt <= '0;
        swclkQ <= ~swclkQ;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
      if (fallEv) begin
        case (phase)
          PH_REQ: begin
            if (bitCnt == REQ_LAST) begin
              phase  <= PH_TRN1;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + CNT_W'(1);
            end
          end
          PH_TRN1: begin
            phase  <= PH_ACK;
            bitCnt <= '0;
          end
          PH_ACK: begin
            if (bitCnt == ACK_LAST) begin
              bitCnt <= '0;
              if (!ackOk)      phase <= PH_TRN3;
              else if (isRead) phase <= PH_RDATA;
              else             phase <= PH_TRN2;
            end else begin
              bitCnt <= bitCnt + CNT_W'(1);
            end
          end
          PH_TRN2: begin
            phase  <= PH_WDATA;
            bitCnt <= '0;
          end
          PH_WDATA: begin
            if (bitCnt == DATA_LAST) phase <= PH_IDLE;
            else                     bitCnt <= bitCnt + CNT_W'(1);
          end
          PH_RDATA: begin
            if (bitCnt == DATA_LAST) begin
              phase  <= PH_TRN3;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + CNT_W'(1);
            end
          end
          PH_TRN3: phase <= PH_IDLE;
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    stb           = '0;
    stb.load      = !busy && cmdStart;
    stb.shiftReq  = fallEv && (phase == PH_REQ);
    stb.shiftWr   = fallEv && (phase == PH_WDATA);
    stb.sampleAck = riseEv && (phase == PH_ACK);
    stb.sampleRd  = riseEv && (phase == PH_RDATA) && (bitCnt != DATA_LAST);
    stb.samplePar = riseEv && (phase == PH_RDATA) && (bitCnt == DATA_LAST);
    stb.finish    = fallEv && (((phase == PH_WDATA) && (bitCnt == DATA_LAST))
                               || (phase == PH_TRN3));
    stb.drvEn     = (phase == PH_IDLE) || (phase == PH_REQ) || (phase == PH_WDATA);
    case (phase)
      PH_REQ:   stb.drvSel = DRV_REQ;
      PH_WDATA: stb.drvSel = (bitCnt == DATA_LAST) ? DRV_WPAR : DRV_WDATA;
      default:  stb.drvSel = DRV_IDLE;
    endcase
  end

  // R9: a transfer begins only from a start pulse
  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdStart));

  // R8: wire clock rests low whenever no transfer runs
  p_idle_clk_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !swclk);

endmodule

// File: rtl/swd_xfer_dp.sv
`timescale 1ns/1ps
module swd_xfer_dp
  import swd_xfer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              cmdApSel,
  input  logic              cmdRead,
  input  logic [1:0]        cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic              swdioIn,
  output logic              ackOk,
  output logic              swdioOut,
  output logic              swdioOe,
  output logic [2:0]        ack,
  output logic [DATA_W-1:0] rdata,
  output logic              parityErr,
  output logic              done
);

  logic [7:0]        reqSh;
  logic [DATA_W-1:0] wSh;
  logic              wPar;
  logic [2:0]        ackSh;
  logic [DATA_W-1:0] rSh;
  logic              rPar;
  logic              rdFlag;
  logic              reqPar;

  assign reqPar = cmdApSel ^ cmdRead ^ cmdAddr[0] ^ cmdAddr[1];
  assign ackOk  = (ackSh == ACK_OK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSh     <= '0;
      wSh       <= '0;
      wPar      <= 1'b0;
      ackSh     <= '0;
      rSh       <= '0;
      rPar      <= 1'b0;
      rdFlag    <= 1'b0;
      ack       <= '0;
      rdata     <= '0;
      parityErr <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.load) begin
        // wire order, first bit in position 0
        reqSh  <= {1'b1, 1'b0, reqPar, cmdAddr[1], cmdAddr[0], cmdRead, cmdApSel, 1'b1};
        wSh    <= cmdWdata;
        wPar   <= ^cmdWdata;
        rdFlag <= cmdRead;
        ackSh  <= '0;
      end
      if (stb.shiftReq)  reqSh <= {1'b0, reqSh[7:1]};
      if (stb.shiftWr)   wSh   <= {1'b0, wSh[DATA_W-1:1]};
      if (stb.sampleAck) ackSh <= {swdioIn, ackSh[2:1]};
      if (stb.sampleRd)  rSh   <= {swdioIn, rSh[DATA_W-1:1]};
      if (stb.samplePar) rPar  <= swdioIn;
      if (stb.finish) begin
        ack <= ackSh;
        if (rdFlag && ackOk) begin
          rdata     <= rSh;
          parityErr <= (^rSh) ^ rPar;
        end else begin
          parityErr <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (stb.drvSel)
      DRV_REQ:   swdioOut = reqSh[0];
      DRV_WDATA: swdioOut = wSh[0];
      DRV_WPAR:  swdioOut = wPar;
      default:   swdioOut = 1'b0;
    endcase
  end
  assign swdioOe = stb.drvEn;

  // R3: reported acknowledge moves only together with completion
  p_ack_with_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ack) |-> done);

  // R6: a parity error appears only at the end of a read
  p_perr_on_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> (done && rdFlag));

endmodule

// File: rtl/swd_xfer_engine.sv
`timescale 1ns/1ps
module swd_xfer_engine
  import swd_xfer_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic              cmdStart,
  input  logic              cmdApSel,
  input  logic              cmdRead,
  input  logic [1:0]        cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic              busy,
  output logic              done,
  output logic [2:0]        ack,
  output logic [DATA_W-1:0] rdata,
  output logic              parityErr,
  output logic              swclk,
  output logic              swdioOut,
  output logic              swdioOe,
  input  logic              swdioIn
);

  strobe_t stb;
  logic    ackOk;

  swd_xfer_ctrl #(.DIV_W(DIV_W), .DATA_W(DATA_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .divHalf  (divHalf),
    .cmdStart (cmdStart),
    .cmdRead  (cmdRead),
    .ackOk    (ackOk),
    .stb      (stb),
    .swclk    (swclk),
    .busy     (busy)
  );

  swd_xfer_dp #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cmdApSel  (cmdApSel),
    .cmdRead   (cmdRead),
    .cmdAddr   (cmdAddr),
    .cmdWdata  (cmdWdata),
    .swdioIn   (swdioIn),
    .ackOk     (ackOk),
    .swdioOut  (swdioOut),
    .swdioOe   (swdioOe),
    .ack       (ack),
    .rdata     (rdata),
    .parityErr (parityErr),
    .done      (done)
  );

  // R8: pin outputs hold while the wire clock stays high
  p_pin_stable_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (swclk && $past(swclk)) |-> ($stable(swdioOut) && $stable(swdioOe)));

  // R8: completion only with the wire clock low
  p_done_clk_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !swclk);

  // R9: completion lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: tb/swd_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module swd_xfer_engine_tb_top;

  localparam int DIV_W  = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DIV_W-1:0]  divHalf = '0;
  logic              cmdStart = 1'b0;
  logic              cmdApSel = 1'b0;
  logic              cmdRead = 1'b0;
  logic [1:0]        cmdAddr = '0;
  logic [DATA_W-1:0] cmdWdata = '0;
  logic              busy, done, parityErr, swclk, swdioOut, swdioOe;
  logic [2:0]        ack;
  logic [DATA_W-1:0] rdata;
  logic              swdioIn = 1'b1;

  always #2 clk = ~clk;

  swd_xfer_engine #(.DIV_W(DIV_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .divHalf(divHalf), .cmdStart(cmdStart),
    .cmdApSel(cmdApSel), .cmdRead(cmdRead), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .busy(busy), .done(done), .ack(ack), .rdata(rdata), .parityErr(parityErr),
    .swclk(swclk), .swdioOut(swdioOut), .swdioOe(swdioOe), .swdioIn(swdioIn)
  );

  typedef struct {
    logic [2:0]        ack;
    logic [DATA_W-1:0] rdata;
    logic              perr;
  } exp_t;

  exp_t              expQ[$];
  int                total = 0;
  int                bad = 0;
  int                riseCnt = 0;
  logic [DATA_W-1:0] rdModel = '0;

  always @(posedge swclk) riseCnt++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  // Monitor: pops one expected result per completion pulse
  always @(negedge clk) begin : monitor
    exp_t e;
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R9", "done without start", 1, 0);
      end else begin
        e = expQ.pop_front();
        chk(ack == e.ack, "R3", "ack", {29'd0, ack}, {29'd0, e.ack});
        chk(rdata == e.rdata, "R5", "rdata", rdata, e.rdata);
        chk(parityErr == e.perr, "R6", "parityErr", {31'd0, parityErr}, {31'd0, e.perr});
      end
    end
  end

  // Driver with target model
  task automatic runXfer(input logic ap, input logic rd, input logic [1:0] addr,
                         input logic [DATA_W-1:0] wd, input logic [2:0] tAck,
                         input logic [DATA_W-1:0] tWord, input bit tBadPar,
                         input int dh, input bit spurious);
    logic [7:0]  reqSeen, reqExp;
    logic [32:0] wrSeen;
    bit          reqOeBad, lineBad, wrOeBad, ok;
    realtime     t0, t1;
    int          r0, expRise, r1;
    exp_t        e;
    ok = (tAck == 3'b001);
    reqSeen = '0; wrSeen = '0; reqOeBad = 0; lineBad = 0; wrOeBad = 0;
    t0 = 0; t1 = 0;
    divHalf = DIV_W'(dh);
    if (rd && ok) rdModel = tWord;
    e.ack = tAck; e.rdata = rdModel; e.perr = rd && ok && tBadPar;
    expQ.push_back(e);
    reqExp = {1'b1, 1'b0, ap ^ rd ^ addr[0] ^ addr[1], addr[1], addr[0], rd, ap, 1'b1};
    r0 = riseCnt;
    @(negedge clk);
    cmdStart = 1'b1; cmdApSel = ap; cmdRead = rd; cmdAddr = addr; cmdWdata = wd;
    @(negedge clk);
    cmdStart = 1'b0;
    fork
      begin
        if (spurious) begin
          repeat (30) @(negedge clk);
          cmdStart = 1'b1; cmdRead = ~rd; cmdAddr = ~addr; cmdApSel = ~ap;
          @(negedge clk);
          cmdStart = 1'b0;
        end
      end
      begin
        for (int i = 0; i < 8; i++) begin
          @(posedge swclk);
          if (i == 0) t0 = $realtime;
          if (i == 1) t1 = $realtime;
          #1;
          reqSeen[i] = swdioOut;
          if (!swdioOe) reqOeBad = 1;
        end
        @(posedge swclk); #1;
        if (swdioOe) lineBad = 1;
        for (int k = 0; k < 3; k++) begin
          @(negedge swclk); #1;
          swdioIn = tAck[k];
          @(posedge swclk); #1;
          if (swdioOe) lineBad = 1;
        end
        if (ok && !rd) begin
          @(posedge swclk); #1;
          if (swdioOe) lineBad = 1;
          for (int j = 0; j < 33; j++) begin
            @(posedge swclk); #1;
            wrSeen[j] = swdioOut;
            if (!swdioOe) wrOeBad = 1;
          end
        end else if (ok) begin
          for (int j = 0; j < 33; j++) begin
            @(negedge swclk); #1;
            swdioIn = (j < 32) ? tWord[j] : ((^tWord) ^ tBadPar);
            @(posedge swclk); #1;
            if (swdioOe) lineBad = 1;
          end
          @(negedge swclk); #1;
          swdioIn = 1'b1;
          @(posedge swclk); #1;
          if (swdioOe) lineBad = 1;
        end else begin
          @(negedge swclk); #1;
          swdioIn = 1'b1;
          @(posedge swclk); #1;
          if (swdioOe) lineBad = 1;
        end
      end
    join
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(!done, "R9", "done width", {31'd0, done}, 0);
    chk(!busy && !swclk, "R9", "idle after done", {30'd0, busy, swclk}, 0);
    chk(reqSeen == reqExp, "R2", "request bits", {24'd0, reqSeen}, {24'd0, reqExp});
    chk(!reqOeBad, "R2", "drive during request", {31'd0, reqOeBad}, 0);
    chk(!lineBad, "R3", "released slots", {31'd0, lineBad}, 0);
    chk((t1 - t0) == 8.0 * (dh + 1), "R8", "wire clock period",
        DATA_W'(int'(t1 - t0)), DATA_W'(8 * (dh + 1)));
    expRise = ok ? 46 : 13;
    if (ok) chk(riseCnt - r0 == expRise, "R10", "pulse count", DATA_W'(riseCnt - r0), DATA_W'(expRise));
    else    chk(riseCnt - r0 == expRise, "R7", "pulse count", DATA_W'(riseCnt - r0), DATA_W'(expRise));
    if (ok && !rd) begin
      chk(wrSeen[31:0] == wd, "R4", "write data", wrSeen[31:0], wd);
      chk(wrSeen[32] == ^wd, "R4", "write parity", {31'd0, wrSeen[32]}, {31'd0, ^wd});
      chk(!wrOeBad, "R4", "drive during data", {31'd0, wrOeBad}, 0);
    end
    if (spurious) begin
      r1 = riseCnt;
      repeat (40) @(negedge clk);
      chk(riseCnt == r1 && !busy, "R9", "start while busy ignored", DATA_W'(riseCnt - r1), 0);
    end
  endtask

  initial begin : watchdog
    #700000;
    chk(1'b0, "R9", "watchdog expired", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(swclk == 1'b0, "R1", "reset swclk", {31'd0, swclk}, 0);
    chk(swdioOe == 1'b1 && swdioOut == 1'b0, "R1", "reset pin", {30'd0, swdioOe, swdioOut}, 2);
    chk(!busy && !done, "R1", "reset busy/done", {30'd0, busy, done}, 0);
    chk(ack == 3'd0 && rdata == '0 && !parityErr, "R1", "reset results", rdata, 0);

    runXfer(1'b0, 1'b1, 2'd0, 32'h0, 3'b001, 32'h2BA0_1477, 1'b0, 0, 1'b0);
    runXfer(1'b0, 1'b0, 2'd2, 32'hA5A5_0F0F, 3'b001, 32'h0, 1'b0, 1, 1'b0);
    runXfer(1'b1, 1'b1, 2'd3, 32'h0, 3'b001, 32'h1234_5678, 1'b1, 2, 1'b0);
    runXfer(1'b1, 1'b0, 2'd1, 32'h0000_0000, 3'b001, 32'h0, 1'b0, 0, 1'b0);
    runXfer(1'b0, 1'b1, 2'd1, 32'h0, 3'b010, 32'hDEAD_BEEF, 1'b0, 1, 1'b0);
    runXfer(1'b1, 1'b0, 2'd0, 32'hFFFF_FFFF, 3'b100, 32'h0, 1'b0, 0, 1'b0);
    runXfer(1'b1, 1'b1, 2'd2, 32'h0, 3'b111, 32'hCAFE_F00D, 1'b1, 2, 1'b0);
    runXfer(1'b0, 1'b1, 2'd3, 32'h0, 3'b001, 32'h8000_0001, 1'b0, 2, 1'b1);
    runXfer(1'b0, 1'b0, 2'd2, 32'h7FFF_FFFE, 3'b000, 32'h0, 1'b0, 1, 1'b0);
    runXfer(1'b1, 1'b0, 2'd3, 32'h0F1E_2D3C, 3'b001, 32'h0, 1'b0, 3, 1'b1);

    repeat (5) @(negedge clk);
    chk(expQ.size() == 0, "R9", "missing done", DATA_W'(expQ.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule